// File: doc/BRIEF.md
# Wait-for-Interrupt Sleep Controller

This block sits beside a processor core's coprocessor register file. It watches the decoded coprocessor write bus for a request to wait for an interrupt. On such a write it stalls the core, drops the core clock enable and asks the cache and tightly coupled memories to go into low power. It stays that way until a wake event arrives. While the core sleeps, the write buffer keeps draining, so the drain enable follows the buffer's fill state in every state.

Two encodings of the request are accepted: a preferred one and an older one, with identical effect. Fast and normal interrupt lines wake the core whatever their mask bits say. Debug requests, either from an external pin or from a request bit in the debug control register, wake it only while debug is enabled. The asynchronous lines pass through two-flop synchronizers first.

On the exit cycle the block reports a one-hot wake cause. It also flags whether the core must take the interrupt, or enter debug state, before its next instruction.

The controller has three states. `ST_RUN` is normal execution. `ST_SLEEP` is the stalled, low-power state. `ST_WAKE` is the one-cycle exit state. The transitions are:
- **sleep-enter**: `ST_RUN` to `ST_SLEEP`, on a matching write when no wake condition is present.
- **wake-detect**: `ST_SLEEP` to `ST_WAKE`, on any qualified wake condition.
- **resume**: `ST_WAKE` to `ST_RUN`, always.
- **hold-run**: stay in `ST_RUN`.
- **hold-sleep**: stay in `ST_SLEEP`.

Top module: `wfi_ctrl`

## Requirements
- R1: After reset the block is in `ST_RUN`: `core_clk_en`=1, `core_stall`=0, `mem_lp_req`=0, `wake_cause`=0, `irq_take_req`=0, `dbg_entry_req`=0.
- R2: A write with `cpw_valid`=1, `cpw_op1`=0, `cpw_crn`=7, `cpw_crm`=0 and `cpw_op2`=4, seen in `ST_RUN`, puts the block into `ST_SLEEP` at that clock edge.
- R3: A write with `cpw_op1`=0, `cpw_crn`=15, `cpw_crm`=8 and `cpw_op2`=2 has exactly the same effect as R2.
- R4: Any other field combination, or either encoding with `cpw_valid`=0, leaves the block in `ST_RUN`.
- R5: In `ST_SLEEP`, `core_clk_en`=0, `core_stall`=1 and `mem_lp_req`=1. In the other states these outputs are 1, 0 and 0.
- R6: Driving `fiq_n` or `irq_n` low wakes the block whatever `fiq_unmasked` and `irq_unmasked` are. The raw line passes two synchronizer flops, so the block shows `ST_WAKE` after the third rising edge that follows the line going low, and is still asleep after the second.
- R7: A debug wake comes from `ext_dbg_req` (synchronized, same latency as R6) or from `dbg_ctl_req` (synchronous, acts at the next edge). It is honoured only while `dbg_en`=1. Otherwise the block stays in `ST_SLEEP`.
- R8: `ST_WAKE` lasts exactly one cycle, then the block returns to `ST_RUN`. During it, `wake_cause` is one-hot, with bit 2 for debug, bit 1 for FIQ and bit 0 for IRQ. When several causes coincide, priority is debug over FIQ over IRQ. `wake_cause` is zero in every other state.
- R9: In `ST_WAKE`, `dbg_entry_req` is 1 exactly when the cause is debug. `irq_take_req` is 1 exactly when the cause is FIQ with `fiq_unmasked`=1, or IRQ with `irq_unmasked`=1. Both are 0 in other states.
- R10: `wbuf_drain_en` equals the inverse of `wbuf_empty` in every state, including `ST_SLEEP`.
- R11: A wait request is ignored if a qualified wake condition is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpw_valid | input | 1 | Coprocessor write strobe |
| cpw_op1 | input | 3 | Write opcode1 field |
| cpw_crn | input | 4 | Write primary register number |
| cpw_crm | input | 4 | Write secondary register number |
| cpw_op2 | input | 3 | Write opcode2 field |
| fiq_n | input | 1 | Fast interrupt, active low, asynchronous |
| irq_n | input | 1 | Normal interrupt, active low, asynchronous |
| ext_dbg_req | input | 1 | External debug request, asynchronous |
| dbg_ctl_req | input | 1 | Debug control register request bit |
| dbg_en | input | 1 | Debug enable |
| fiq_unmasked | input | 1 | Fast interrupts enabled in the core |
| irq_unmasked | input | 1 | Normal interrupts enabled in the core |
| wbuf_empty | input | 1 | Write buffer empty |
| core_stall | output | 1 | Core stall |
| core_clk_en | output | 1 | Core clock enable |
| mem_lp_req | output | 1 | Cache and tightly coupled memory low-power request |
| wbuf_drain_en | output | 1 | Write buffer drain enable |
| wake_cause | output | 3 | One-hot wake cause {debug, FIQ, IRQ} |
| irq_take_req | output | 1 | Take interrupt before the next instruction |
| dbg_entry_req | output | 1 | Enter debug state before the next instruction |

## Verification
The bench tries encodings that differ from a valid request in a single field, such as opcode1, opcode2 or CRm. A decoder that ignored one field would stall the core on an unrelated write. Debug requests are applied with the enable low, and simultaneous causes are applied together. A block that woke without the enable, or ranked the causes wrongly, shows the wrong one-hot bit or leaves sleep. The bench samples one edge before and one edge at the expected synchronizer latency, checks masked interrupts, and holds a wake line low while the request is issued. These expose a missing flop stage, wake logic that honours the mask, and a controller that sleeps with an interrupt already pending.

// File: rtl/wfi_pkg.sv
package wfi_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } wfi_state_e;

    localparam int CAUSE_W   = 3;
    localparam int CAUSE_DBG = 2;
    localparam int CAUSE_FIQ = 1;
    localparam int CAUSE_IRQ = 0;

endpackage

// File: rtl/wfi_sync.sv
module wfi_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wfi_decode.sv
module wfi_decode #(
    parameter int            OP1_W         = 3,
    parameter int            CRN_W         = 4,
    parameter int            CRM_W         = 4,
    parameter int            OP2_W         = 3,
    parameter bit            ACCEPT_LEGACY = 1'b1,
    parameter logic [OP1_W-1:0] PRI_OP1    = 3'd0,
    parameter logic [CRN_W-1:0] PRI_CRN    = 4'd7,
    parameter logic [CRM_W-1:0] PRI_CRM    = 4'd0,
    parameter logic [OP2_W-1:0] PRI_OP2    = 3'd4,
    parameter logic [OP1_W-1:0] LEG_OP1    = 3'd0,
    parameter logic [CRN_W-1:0] LEG_CRN    = 4'd15,
    parameter logic [CRM_W-1:0] LEG_CRM    = 4'd8,
    parameter logic [OP2_W-1:0] LEG_OP2    = 3'd2
) (
    input  logic             valid,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output logic             wait_req
);

    logic hit_pri;
    logic hit_leg;

    assign hit_pri = (op1 == PRI_OP1) && (crn == PRI_CRN) &&
                     (crm == PRI_CRM) && (op2 == PRI_OP2);

    generate
        if (ACCEPT_LEGACY) begin : g_legacy
            assign hit_leg = (op1 == LEG_OP1) && (crn == LEG_CRN) &&
                             (crm == LEG_CRM) && (op2 == LEG_OP2);
        end else begin : g_no_legacy
            assign hit_leg = 1'b0;
        end
    endgenerate

    assign wait_req = valid && (hit_pri || hit_leg);

endmodule

// File: rtl/wfi_wake.sv
module wfi_wake
    import wfi_pkg::*;
(
    input  logic               fiq_act,
    input  logic               irq_act,
    input  logic               dbg_ext_act,
    input  logic               dbg_ctl,
    input  logic               dbg_en,
    output logic               wake_any,
    output logic [CAUSE_W-1:0] cause
);

    logic dbg_wake;

    // Debug wake only counts while debug is enabled; interrupt lines ignore masks
    assign dbg_wake = dbg_en && (dbg_ext_act || dbg_ctl);

    always_comb begin
        cause = '0;
        if (dbg_wake) begin
            cause[CAUSE_DBG] = 1'b1;
        end else if (fiq_act) begin
            cause[CAUSE_FIQ] = 1'b1;
        end else if (irq_act) begin
            cause[CAUSE_IRQ] = 1'b1;
        end
    end

    assign wake_any = dbg_wake || fiq_act || irq_act;

endmodule

// File: rtl/wfi_ctrl.sv
module wfi_ctrl
    import wfi_pkg::*;
#(
    parameter int OP1_W       = 3,
    parameter int CRN_W       = 4,
    parameter int CRM_W       = 4,
    parameter int OP2_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpw_valid,
    input  logic [OP1_W-1:0] cpw_op1,
    input  logic [CRN_W-1:0] cpw_crn,
    input  logic [CRM_W-1:0] cpw_crm,
    input  logic [OP2_W-1:0] cpw_op2,
    input  logic             fiq_n,
    input  logic             irq_n,
    input  logic             ext_dbg_req,
    input  logic             dbg_ctl_req,
    input  logic             dbg_en,
    input  logic             fiq_unmasked,
    input  logic             irq_unmasked,
    input  logic             wbuf_empty,
    output logic             core_stall,
    output logic             core_clk_en,
    output logic             mem_lp_req,
    output logic             wbuf_drain_en,
    output logic [2:0]       wake_cause,
    output logic             irq_take_req,
    output logic             dbg_entry_req
);

    localparam int ASYNC_W = 3;

    wfi_state_e         state_q, state_d;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] cause_next;
    logic [ASYNC_W-1:0] async_raw;
    logic [ASYNC_W-1:0] async_sync;
    logic               wait_req;
    logic               wake_any;

    // Active-high versions of the asynchronous lines: {debug, fiq, irq}
    assign async_raw = {ext_dbg_req, ~fiq_n, ~irq_n};

    wfi_sync #(
        .WIDTH   (ASYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_raw),
        .q     (async_sync)
    );

    wfi_decode #(
        .OP1_W (OP1_W),
        .CRN_W (CRN_W),
        .CRM_W (CRM_W),
        .OP2_W (OP2_W)
    ) u_decode (
        .valid    (cpw_valid),
        .op1      (cpw_op1),
        .crn      (cpw_crn),
        .crm      (cpw_crm),
        .op2      (cpw_op2),
        .wait_req (wait_req)
    );

    wfi_wake u_wake (
        .fiq_act     (async_sync[1]),
        .irq_act     (async_sync[0]),
        .dbg_ext_act (async_sync[2]),
        .dbg_ctl     (dbg_ctl_req),
        .dbg_en      (dbg_en),
        .wake_any    (wake_any),
        .cause       (cause_next)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wait_req && !wake_any) begin
                    state_d = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (wake_any) begin
                    state_d = ST_WAKE;
                end
            end
            ST_WAKE: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // State register and cause capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SLEEP && wake_any) begin
                cause_q <= cause_next;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        core_stall    = 1'b0;
        core_clk_en   = 1'b1;
        mem_lp_req    = 1'b0;
        wake_cause    = '0;
        irq_take_req  = 1'b0;
        dbg_entry_req = 1'b0;
        wbuf_drain_en = !wbuf_empty;
        unique case (state_q)
            ST_RUN: begin
            end
            ST_SLEEP: begin
                core_stall  = 1'b1;
                core_clk_en = 1'b0;
                mem_lp_req  = 1'b1;
            end
            ST_WAKE: begin
                wake_cause    = cause_q;
                dbg_entry_req = cause_q[CAUSE_DBG];
                irq_take_req  = (cause_q[CAUSE_FIQ] && fiq_unmasked) ||
                                (cause_q[CAUSE_IRQ] && irq_unmasked);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/wfi_ctrl_chk.sv
module wfi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_en,
    input logic       wbuf_empty,
    input logic       core_stall,
    input logic       core_clk_en,
    input logic       mem_lp_req,
    input logic       wbuf_drain_en,
    input logic [2:0] wake_cause,
    input logic       dbg_entry_req,
    input logic       irq_take_req
);

    // R5
    sleep_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> (!core_clk_en && mem_lp_req));

    // R8
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_cause));

    // R8
    cause_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_cause) |=> (wake_cause == 3'b000 && !core_stall));

    // R8
    exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_stall) |-> (|wake_cause));

    // R10
    drain_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_stall && !wbuf_empty) |-> wbuf_drain_en);

    // R7
    dbg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_cause[2] |-> $past(dbg_en));

    // R9
    dbg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_entry_req |-> wake_cause[2]);

    // R9
    take_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_req |-> (wake_cause[1] || wake_cause[0]));

endmodule

bind wfi_ctrl wfi_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbg_en        (dbg_en),
    .wbuf_empty    (wbuf_empty),
    .core_stall    (core_stall),
    .core_clk_en   (core_clk_en),
    .mem_lp_req    (mem_lp_req),
    .wbuf_drain_en (wbuf_drain_en),
    .wake_cause    (wake_cause),
    .dbg_entry_req (dbg_entry_req),
    .irq_take_req  (irq_take_req)
);

// File: tb/wfi_ctrl_bench.sv
module wfi_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpw_valid = 1'b0;
    logic [2:0] cpw_op1 = '0;
    logic [3:0] cpw_crn = '0;
    logic [3:0] cpw_crm = '0;
    logic [2:0] cpw_op2 = '0;
    logic       fiq_n = 1'b1;
    logic       irq_n = 1'b1;
    logic       ext_dbg_req = 1'b0;
    logic       dbg_ctl_req = 1'b0;
    logic       dbg_en = 1'b0;
    logic       fiq_unmasked = 1'b0;
    logic       irq_unmasked = 1'b0;
    logic       wbuf_empty = 1'b1;
    logic       core_stall, core_clk_en, mem_lp_req, wbuf_drain_en;
    logic [2:0] wake_cause;
    logic       irq_take_req, dbg_entry_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wfi_ctrl u_wfi_ctrl (
        .clk(clk), .rst_n(rst_n), .cpw_valid(cpw_valid), .cpw_op1(cpw_op1),
        .cpw_crn(cpw_crn), .cpw_crm(cpw_crm), .cpw_op2(cpw_op2),
        .fiq_n(fiq_n), .irq_n(irq_n), .ext_dbg_req(ext_dbg_req),
        .dbg_ctl_req(dbg_ctl_req), .dbg_en(dbg_en),
        .fiq_unmasked(fiq_unmasked), .irq_unmasked(irq_unmasked),
        .wbuf_empty(wbuf_empty), .core_stall(core_stall),
        .core_clk_en(core_clk_en), .mem_lp_req(mem_lp_req),
        .wbuf_drain_en(wbuf_drain_en), .wake_cause(wake_cause),
        .irq_take_req(irq_take_req), .dbg_entry_req(dbg_entry_req)
    );

    // [26:24] op1 [23:20] crn [19:16] crm [15:13] op2 [12:9] src {ctl,ext,fiq,irq}
    // [8] dbg_en [7] fiq_unmasked [6] irq_unmasked [5] exp sleep [4:2] exp cause
    // [1] exp take [0] exp debug entry
    localparam int NV = 16;
    localparam logic [26:0] VEC [NV] = '{
        {3'd0, 4'd7,  4'd0, 3'd4, 4'b0001, 3'b001, 1'b1, 3'b001, 1'b1, 1'b0},
        {3'd0, 4'd15, 4'd8, 3'd2, 4'b0010, 3'b000, 1'b1, 3'b010, 1'b0, 1'b0},
        {3'd0, 4'd7,  4'd0, 3'd4, 4'b0010, 3'b010, 1'b1, 3'b010, 1'b1, 1'b0},
        {3'd0, 4'd15, 4'd8, 3'd2, 4'b0001, 3'b010, 1'b1, 3'b001, 1'b0, 1'b0},
        {3'd0, 4'd7,  4'd0, 3'd4, 4'b0100, 3'b100, 1'b1, 3'b100, 1'b0, 1'b1},
        {3'd0, 4'd7,  4'd0, 3'd4, 4'b0100, 3'b000, 1'b1, 3'b000, 1'b0, 1'b0},
        {3'd0, 4'd7,  4'd0, 3'd4, 4'b1000, 3'b100, 1'b1, 3'b100, 1'b0, 1'b1},
        {3'd0, 4'd7,  4'd0, 3'd4, 4'b1000, 3'b000, 1'b1, 3'b000, 1'b0, 1'b0},
        {3'd0, 4'd7,  4'd0, 3'd4, 4'b0011, 3'b011, 1'b1, 3'b010, 1'b1, 1'b0},
        {3'd0, 4'd15, 4'd8, 3'd2, 4'b0111, 3'b111, 1'b1, 3'b100, 1'b0, 1'b1},
        {3'd0, 4'd15, 4'd8, 3'd2, 4'b0111, 3'b001, 1'b1, 3'b010, 1'b0, 1'b0},
        {3'd1, 4'd7,  4'd0, 3'd4, 4'b0000, 3'b000, 1'b0, 3'b000, 1'b0, 1'b0},
        {3'd0, 4'd7,  4'd0, 3'd5, 4'b0000, 3'b000, 1'b0, 3'b000, 1'b0, 1'b0},
        {3'd0, 4'd15, 4'd8, 3'd3, 4'b0000, 3'b000, 1'b0, 3'b000, 1'b0, 1'b0},
        {3'd0, 4'd7,  4'd8, 3'd4, 4'b0000, 3'b000, 1'b0, 3'b000, 1'b0, 1'b0},
        {3'd0, 4'd15, 4'd0, 3'd2, 4'b0000, 3'b000, 1'b0, 3'b000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_src(input logic [3:0] s);
        dbg_ctl_req = s[3];
        ext_dbg_req = s[2];
        fiq_n       = !s[1];
        irq_n       = !s[0];
    endtask

    task automatic issue(input logic [2:0] o1, input logic [3:0] n,
                         input logic [3:0] m, input logic [2:0] o2);
        @(negedge clk);
        cpw_valid = 1'b1; cpw_op1 = o1; cpw_crn = n; cpw_crm = m; cpw_op2 = o2;
        @(posedge clk); #1;
        @(negedge clk);
        cpw_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected<20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 clk_en", 8'(core_clk_en), 8'd1);
        chk("R1 stall", 8'(core_stall), 8'd0);
        chk("R1 mem_lp", 8'(mem_lp_req), 8'd0);
        chk("R1 cause", 8'(wake_cause), 8'd0);
        chk("R1 take/dbg", 8'({irq_take_req, dbg_entry_req}), 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [26:0] e;
            int lat;
            string tag;
            e = VEC[v];
            tag = e[5] ? ((e[23:20] == 4'd15) ? "R3" : "R2") : "R4";
            @(negedge clk);
            cpw_valid = 1'b1;
            cpw_op1 = e[26:24]; cpw_crn = e[23:20]; cpw_crm = e[19:16]; cpw_op2 = e[15:13];
            dbg_en = e[8]; fiq_unmasked = e[7]; irq_unmasked = e[6];
            @(posedge clk); #1;
            chk(tag, 8'(core_stall), 8'(e[5]));
            // R5: sleep-state outputs
            chk("R5 clk_en", 8'(core_clk_en), 8'(!e[5]));
            chk("R5 mem_lp", 8'(mem_lp_req), 8'(e[5]));
            @(negedge clk);
            cpw_valid = 1'b0;
            if (e[5]) begin
                put_src(e[12:9]);
                lat = (e[12] && e[8]) ? 1 : 3;
                repeat (lat) @(posedge clk);
                #1;
                // R8 cause and priority, R9 follow-up requests
                chk("R8 cause", 8'(wake_cause), 8'(e[4:2]));
                chk("R9 take", 8'(irq_take_req), 8'(e[1]));
                chk("R9 dbg entry", 8'(dbg_entry_req), 8'(e[0]));
                if (e[4:2] == 3'b000) begin
                    // R7: debug wake without enable keeps the core asleep
                    chk("R7 still asleep", 8'(core_stall), 8'd1);
                    @(negedge clk);
                    put_src(4'b0001);
                    repeat (3) @(posedge clk);
                    @(negedge clk);
                    put_src(4'b0000);
                    @(posedge clk);
                end else begin
                    @(negedge clk);
                    put_src(4'b0000);
                    @(posedge clk); #1;
                    chk("R8 back to run", 8'({core_stall, wake_cause}), 8'd0);
                end
            end
            repeat (3) @(posedge clk);
        end

        // R6: latency through synchronizer, mask ignored
        fiq_unmasked = 1'b0; irq_unmasked = 1'b0; dbg_en = 1'b0;
        issue(3'd0, 4'd7, 4'd0, 3'd4);
        irq_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk("R6 asleep at edge 2", 8'(core_stall), 8'd1);
        @(posedge clk); #1;
        chk("R6 woken at edge 3", 8'({core_stall, wake_cause}), 8'b0001);
        @(negedge clk);
        irq_n = 1'b1;
        repeat (4) @(posedge clk);

        // R10: drain enable while sleeping
        issue(3'd0, 4'd15, 4'd8, 3'd2);
        wbuf_empty = 1'b0; #1;
        chk("R10 drain in sleep", 8'({core_stall, wbuf_drain_en}), 8'b11);
        @(negedge clk);
        wbuf_empty = 1'b1; #1;
        chk("R10 drain stops when empty", 8'({core_stall, wbuf_drain_en}), 8'b10);
        fiq_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        fiq_n = 1'b1;
        @(negedge clk);
        wbuf_empty = 1'b0; #1;
        chk("R10 drain in run", 8'({core_stall, wbuf_drain_en}), 8'b01);
        wbuf_empty = 1'b1;
        repeat (4) @(posedge clk);

        // R11: pending interrupt blocks the request
        @(negedge clk);
        irq_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cpw_valid = 1'b1; cpw_op1 = 3'd0; cpw_crn = 4'd7; cpw_crm = 4'd0; cpw_op2 = 3'd4;
        @(posedge clk); #1;
        chk("R11 irq pending", 8'(core_stall), 8'd0);
        @(negedge clk);
        cpw_valid = 1'b0; irq_n = 1'b1;
        repeat (4) @(posedge clk);

        // R11: debug control bit pending with debug enabled
        @(negedge clk);
        dbg_en = 1'b1; dbg_ctl_req = 1'b1;
        cpw_valid = 1'b1; cpw_crn = 4'd15; cpw_crm = 4'd8; cpw_op2 = 3'd2;
        @(posedge clk); #1;
        chk("R11 debug pending", 8'(core_stall), 8'd0);
        @(negedge clk);
        cpw_valid = 1'b0; dbg_ctl_req = 1'b0;

        // R4: valid strobe low
        @(negedge clk);
        cpw_valid = 1'b0; cpw_crn = 4'd7; cpw_crm = 4'd0; cpw_op2 = 3'd4;
        @(posedge clk); #1;
        chk("R4 valid low", 8'(core_stall), 8'd0);

        done = 1'b1;
        finish_run();
    end

endmodule